// File: doc/BRIEF.md
# Digital Lock-In Demodulator

This block pulls out the part of a sampled detector signal that follows a reference modulation tone, producing a slowly varying error value for a laser peak-lock loop. A phase accumulator with a programmable step sets the reference frequency. For every accepted input sample, an iterative rotator turns the current phase into a sine and a cosine. The sine becomes the modulation output that drives the laser, so the tone applied and the tone used for detection are the same.

The input sample is multiplied by the cosine. The product holds a DC term proportional to the in-phase amplitude plus a term at twice the modulation frequency. A second-order recursive low-pass section removes the double-frequency term. Its coefficients come in as Q2.14 values, which a host sets to a Butterworth response with a cutoff of a few hertz. The filtered value crosses zero at the top of the absorption line, so it can serve directly as the error of a lock loop.

The phase advances by one step for each accepted sample. Each result appears with a fixed delay after its sample, marked by a one-cycle strobe.

Top module: `lockin_demod`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the phase, the filter history and all outputs to zero. The first sample after reset uses phase 0, and its filter output holds no earlier state.
- R2: Each accepted sample uses the phase accumulated before it and then advances the 24-bit phase by `phase_inc`, modulo 2^24. Phase 2^24 equals one full turn, so sample k uses phase k*`phase_inc` mod 2^24.
- R3: `mod_out` becomes round(32767*sin(2*pi*phase/2^24)) of the sample's phase, within 12 LSB, in all four quadrants. It is updated one cycle before the matching `err_valid`.
- R4: The value fed to the filter is (sample * cosine) >>> 15, where the cosine is 32767*cos of the same phase. With b0 = 16384 and the other coefficients 0, `err_out` equals sample*cos(phase) within 8 LSB.
- R5: The filter is direct form I: acc = b0*x[n] + b1*x[n-1] + b2*x[n-2] - a1*y[n-1] - a2*y[n-2], with signed Q2.14 coefficients, and `err_out` = y[n] = acc >>> 14. History moves only on accepted samples.
- R6: acc saturates to the 32-bit signed range before the shift. A runaway filter holds `err_out` at 131071 or -131072 and never wraps.
- R7: `err_valid` is a one-cycle pulse 18 clock edges after the edge that accepts the sample (16 rotator iterations plus 2 register stages).
- R8: A `sample_valid` that arrives while the rotator is busy is ignored. It does not step the phase, does not produce a result and does not enter the filter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_inc | input | 24 | Phase step per accepted sample |
| coef_b0 | input | 16 | Feed-forward coefficient for x[n], signed Q2.14 |
| coef_b1 | input | 16 | Feed-forward coefficient for x[n-1], signed Q2.14 |
| coef_b2 | input | 16 | Feed-forward coefficient for x[n-2], signed Q2.14 |
| coef_a1 | input | 16 | Feedback coefficient for y[n-1], signed Q2.14 |
| coef_a2 | input | 16 | Feedback coefficient for y[n-2], signed Q2.14 |
| sample_valid | input | 1 | Input sample strobe |
| sample_in | input | 16 | Signed detector sample |
| mod_out | output | 16 | Signed sine reference for the modulator |
| err_out | output | 18 | Signed filtered error value |
| err_valid | output | 1 | One-cycle strobe marking a new err_out |

## Verification
Each sample is driven on a falling edge and accepted at the next rising edge. The bench then counts rising edges until `err_valid` shows high at a falling edge, and expects exactly 18. It reads `err_out` and `mod_out` in that same half-cycle, after the sine has had one cycle to settle. A sample sent 4 cycles into a busy window is followed by a 40-cycle watch that must see exactly one strobe. The next real sample must show a phase that moved only once. The expected values come from real-number sine and cosine and from integer filter recursions with stated tolerances. The saturation limits are compared exactly.

// File: rtl/lockin_pkg.sv
package lockin_pkg;

    localparam int COEF_W = 16;

    typedef struct packed {
        logic signed [COEF_W-1:0] b0;
        logic signed [COEF_W-1:0] b1;
        logic signed [COEF_W-1:0] b2;
        logic signed [COEF_W-1:0] a1;
        logic signed [COEF_W-1:0] a2;
    } coef_t;

    // arctan(2^-i) expressed in units of 2^-24 turn, rescaled to the phase width
    function automatic logic [31:0] atan_turns(input int idx, input int pw);
        logic [31:0] t;
        case (idx)
            0:  t = 32'd2097152;
            1:  t = 32'd1238021;
            2:  t = 32'd654137;
            3:  t = 32'd332052;
            4:  t = 32'd166669;
            5:  t = 32'd83416;
            6:  t = 32'd41718;
            7:  t = 32'd20860;
            8:  t = 32'd10430;
            9:  t = 32'd5215;
            10: t = 32'd2608;
            11: t = 32'd1304;
            12: t = 32'd652;
            13: t = 32'd326;
            14: t = 32'd163;
            15: t = 32'd81;
            default: t = 32'd0;
        endcase
        if (pw >= 24) return t << (pw - 24);
        else          return t >> (24 - pw);
    endfunction

endpackage

// File: rtl/lockin_nco.sv
module lockin_nco #(
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [PHASE_W-1:0] inc,
    output logic [PHASE_W-1:0] phase
);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
    } nco_st_t;

    nco_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) st_d.acc = st_q.acc + inc;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase = st_q.acc;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (st_q.acc == $past(st_q.acc + inc))); // R2

endmodule

// File: rtl/lockin_cordic.sv
module lockin_cordic
    import lockin_pkg::*;
#(
    parameter int PHASE_W = 24,
    parameter int OUT_W   = 16,
    parameter int ITER    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [PHASE_W-1:0]      phase,
    output logic                    busy,
    output logic                    done,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o
);

    localparam int CNT_W = $clog2(ITER + 1);
    localparam int XW    = OUT_W + 2;
    localparam longint FULL = (longint'(1) <<< (OUT_W - 1)) - 1;
    localparam longint X0   = FULL * 607253 / 1000000;
    localparam logic signed [XW-1:0] X_INIT = XW'(X0);
    localparam logic signed [XW-1:0] POS_LIM = XW'(FULL);
    localparam logic signed [XW-1:0] NEG_LIM = -XW'(FULL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic                    flip;
        logic [CNT_W-1:0]        cnt;
        logic signed [XW-1:0]    x;
        logic signed [XW-1:0]    y;
        logic signed [PHASE_W-1:0] z;
        logic signed [OUT_W-1:0] s;
        logic signed [OUT_W-1:0] c;
    } cor_st_t;

    cor_st_t st_d, st_q;

    function automatic logic signed [OUT_W-1:0] clip(input logic signed [XW-1:0] v);
        if (v > POS_LIM)      return OUT_W'(POS_LIM);
        else if (v < NEG_LIM) return OUT_W'(NEG_LIM);
        else                  return OUT_W'(v);
    endfunction

    logic signed [XW-1:0]      xs, ys, nx, ny;
    logic signed [PHASE_W-1:0] ang, nz;
    logic [PHASE_W-1:0]        folded;

    always_comb begin
        st_d   = st_q;
        st_d.done = 1'b0;
        xs     = st_q.x >>> st_q.cnt;
        ys     = st_q.y >>> st_q.cnt;
        ang    = PHASE_W'(atan_turns(int'(st_q.cnt), PHASE_W));
        folded = phase ^ {1'b1, {(PHASE_W-1){1'b0}}};
        if (st_q.z >= 0) begin
            nx = st_q.x - ys;
            ny = st_q.y + xs;
            nz = st_q.z - ang;
        end else begin
            nx = st_q.x + ys;
            ny = st_q.y - xs;
            nz = st_q.z + ang;
        end
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.x    = X_INIT;
                st_d.y    = '0;
                st_d.flip = phase[PHASE_W-1] ^ phase[PHASE_W-2];
                st_d.z    = st_d.flip ? signed'(folded) : signed'(phase);
            end
        end else begin
            st_d.x   = nx;
            st_d.y   = ny;
            st_d.z   = nz;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.s    = clip(st_q.flip ? -ny : ny);
                st_d.c    = clip(st_q.flip ? -nx : nx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign done  = st_q.done;
    assign sin_o = st_q.s;
    assign cos_o = st_q.c;

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (st_q.busy && start) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        st_q.done |=> !st_q.done); // R7

endmodule

// File: rtl/lockin_biquad.sv
module lockin_biquad
    import lockin_pkg::*;
#(
    parameter int XW    = 16,
    parameter int ACC_W = 32,
    parameter int FRAC  = 14
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic signed [XW-1:0]         x_in,
    input  coef_t                        coefs,
    output logic signed [ACC_W-FRAC-1:0] y_out,
    output logic                         y_valid
);

    localparam int YW    = ACC_W - FRAC;
    localparam int SUM_W = ACC_W + 6;
    localparam logic signed [SUM_W-1:0] SUM_HI = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SUM_LO = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};
    localparam logic signed [YW-1:0]    Y_MAX  = {1'b0, {(YW-1){1'b1}}};
    localparam logic signed [YW-1:0]    Y_MIN  = {1'b1, {(YW-1){1'b0}}};

    typedef struct packed {
        logic signed [XW-1:0] x1;
        logic signed [XW-1:0] x2;
        logic signed [YW-1:0] y1;
        logic signed [YW-1:0] y2;
        logic                 vld;
    } bq_st_t;

    bq_st_t st_d, st_q;

    logic signed [SUM_W-1:0] p0, p1, p2, q1, q2, sum;
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        p0  = SUM_W'(coefs.b0) * SUM_W'(x_in);
        p1  = SUM_W'(coefs.b1) * SUM_W'(st_q.x1);
        p2  = SUM_W'(coefs.b2) * SUM_W'(st_q.x2);
        q1  = SUM_W'(coefs.a1) * SUM_W'(st_q.y1);
        q2  = SUM_W'(coefs.a2) * SUM_W'(st_q.y2);
        sum = p0 + p1 + p2 - q1 - q2;
        if (sum > SUM_HI)      acc = ACC_W'(SUM_HI);
        else if (sum < SUM_LO) acc = ACC_W'(SUM_LO);
        else                   acc = ACC_W'(sum);

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.x1 = x_in;
            st_d.x2 = st_q.x1;
            st_d.y1 = YW'(acc >>> FRAC);
            st_d.y2 = st_q.y1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign y_out   = st_q.y1;
    assign y_valid = st_q.vld;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sum > SUM_HI) |=> (st_q.y1 == Y_MAX)); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sum < SUM_LO) |=> (st_q.y1 == Y_MIN)); // R6

    AST_HISTORY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(st_q.y1) && $stable(st_q.x1))); // R5

endmodule

// File: rtl/lockin_demod.sv
module lockin_demod
    import lockin_pkg::*;
#(
    parameter int PHASE_W  = 24,
    parameter int SAMPLE_W = 16,
    parameter int ITER     = 16,
    parameter int ACC_W    = 32,
    parameter int FRAC     = 14
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [PHASE_W-1:0]             phase_inc,
    input  logic signed [COEF_W-1:0]       coef_b0,
    input  logic signed [COEF_W-1:0]       coef_b1,
    input  logic signed [COEF_W-1:0]       coef_b2,
    input  logic signed [COEF_W-1:0]       coef_a1,
    input  logic signed [COEF_W-1:0]       coef_a2,
    input  logic                           sample_valid,
    input  logic signed [SAMPLE_W-1:0]     sample_in,
    output logic signed [SAMPLE_W-1:0]     mod_out,
    output logic signed [ACC_W-FRAC-1:0]   err_out,
    output logic                           err_valid
);

    localparam int PW = 2 * SAMPLE_W;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] samp;
        logic signed [SAMPLE_W-1:0] prod;
        logic                       pvld;
        logic signed [SAMPLE_W-1:0] modv;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                       cor_busy, cor_done, accept;
    logic signed [SAMPLE_W-1:0] ref_sin, ref_cos;
    logic [PHASE_W-1:0]         cur_phase;
    logic signed [PW-1:0]       prod_full;
    coef_t                      coefs;

    assign accept = sample_valid && !cor_busy;
    assign coefs  = '{b0: coef_b0, b1: coef_b1, b2: coef_b2, a1: coef_a1, a2: coef_a2};

    lockin_nco #(.PHASE_W(PHASE_W)) u_nco (
        .clk(clk), .rst(rst), .step(accept), .inc(phase_inc), .phase(cur_phase)
    );

    lockin_cordic #(.PHASE_W(PHASE_W), .OUT_W(SAMPLE_W), .ITER(ITER)) u_cordic (
        .clk(clk), .rst(rst), .start(accept), .phase(cur_phase),
        .busy(cor_busy), .done(cor_done), .sin_o(ref_sin), .cos_o(ref_cos)
    );

    always_comb begin
        st_d      = st_q;
        prod_full = PW'(st_q.samp) * PW'(ref_cos);
        st_d.pvld = cor_done;
        if (accept) st_d.samp = sample_in;
        if (cor_done) begin
            st_d.prod = SAMPLE_W'(prod_full >>> (SAMPLE_W - 1));
            st_d.modv = ref_sin;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    lockin_biquad #(.XW(SAMPLE_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_filt (
        .clk(clk), .rst(rst), .in_valid(st_q.pvld), .x_in(st_q.prod),
        .coefs(coefs), .y_out(err_out), .y_valid(err_valid)
    );

    assign mod_out = st_q.modv;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        err_valid |=> !err_valid); // R7

    AST_MOD_FOLLOWS_REF: assert property (@(posedge clk) disable iff (rst)
        cor_done |=> (mod_out == $past(ref_sin))); // R3

    AST_PRODUCT_BEFORE_FILTER: assert property (@(posedge clk) disable iff (rst)
        st_q.pvld |=> err_valid); // R7

endmodule

// File: tb/tb_lockin_demod.sv
module tb_lockin_demod;

    localparam int CLK_PERIOD = 10;
    localparam real PI = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [23:0]        phase_inc = '0;
    logic signed [15:0] b0 = '0, b1 = '0, b2 = '0, a1 = '0, a2 = '0;
    logic               sample_valid = 1'b0;
    logic signed [15:0] sample_in = '0;
    logic signed [15:0] mod_out;
    logic signed [17:0] err_out;
    logic               err_valid;

    int vectors = 0;
    int fails   = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockin_demod dut (
        .clk(clk), .rst(rst), .phase_inc(phase_inc),
        .coef_b0(b0), .coef_b1(b1), .coef_b2(b2), .coef_a1(a1), .coef_a2(a2),
        .sample_valid(sample_valid), .sample_in(sample_in),
        .mod_out(mod_out), .err_out(err_out), .err_valid(err_valid)
    );

    task automatic check(input string tag, input int actual, input int expected, input int tol);
        int d;
        vectors++;
        d = actual - expected;
        if (d < 0) d = -d;
        if (d > tol) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d (tol %0d)", tag, actual, expected, tol);
        end
    endtask

    function automatic int exp_sin(input longint ph);
        return $rtoi($floor(32767.0 * $sin(2.0 * PI * real'(ph) / 16777216.0) + 0.5));
    endfunction

    function automatic int exp_cos_prod(input int s, input longint ph);
        return $rtoi($floor(real'(s) * $cos(2.0 * PI * real'(ph) / 16777216.0) + 0.5));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_coefs(input int c0, input int c1, input int c2, input int d1, input int d2);
        b0 = 16'(c0); b1 = 16'(c1); b2 = 16'(c2); a1 = 16'(d1); a2 = 16'(d2);
    endtask

    // drives one sample, returns at the half-cycle where err_valid is seen
    task automatic send(input int s, output int y, output int m);
        int lat;
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in    = 16'(s);
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
        lat = 0;
        while (lat < 60) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (err_valid) break;
        end
        check("R7 latency", lat, 18, 0);
        y = int'(err_out);
        m = int'(mod_out);
        @(negedge clk);
        check("R7 single-cycle strobe", int'(err_valid), 0, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R1 err_out after reset", int'(err_out), 0, 0);
        check("R1 err_valid after reset", int'(err_valid), 0, 0);
        check("R1 mod_out after reset", int'(mod_out), 0, 0);
    endtask

    task automatic t_quadrants();
        int y, m;
        do_reset();
        phase_inc = 24'h400000;
        set_coefs(16384, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) begin
            longint ph = (longint'(k) * 64'h400000) & 64'hFFFFFF;
            send(16000, y, m);
            check("R3 quadrant sine", m, exp_sin(ph), 12);
            check("R4 quadrant product", y, exp_cos_prod(16000, ph), 8);
        end
    endtask

    task automatic t_fine_phase();
        int y, m;
        do_reset();
        phase_inc = 24'h155555;
        set_coefs(16384, 0, 0, 0, 0);
        for (int k = 0; k < 14; k++) begin
            longint ph = (longint'(k) * 64'h155555) & 64'hFFFFFF;
            send(-12000, y, m);
            check("R2 phase wrap sine", m, exp_sin(ph), 12);
            check("R4 negative sample product", y, exp_cos_prod(-12000, ph), 8);
        end
    endtask

    task automatic t_feedback();
        int y, m;
        do_reset();
        phase_inc = 24'h0;
        set_coefs(16384, 0, 0, -8192, 0);
        send(8000, y, m); check("R5 a1 step 0", y, 8000, 6);
        send(8000, y, m); check("R5 a1 step 1", y, 12000, 6);
        send(8000, y, m); check("R5 a1 step 2", y, 14000, 6);
        do_reset();
        set_coefs(16384, 0, 0, 0, 8192);
        send(4000, y, m); check("R5 a2 step 0", y, 4000, 6);
        send(4000, y, m); check("R5 a2 step 1", y, 4000, 6);
        send(4000, y, m); check("R5 a2 step 2", y, 2000, 6);
    endtask

    task automatic t_taps();
        int y, m;
        do_reset();
        phase_inc = 24'h0;
        set_coefs(0, 0, 16384, 0, 0);
        send(5000, y, m); check("R5 b2 tap n0", y, 0, 0);
        send(6000, y, m); check("R5 b2 tap n1", y, 0, 0);
        send(7000, y, m); check("R5 b2 tap n2", y, 5000, 6);
        set_coefs(0, 16384, 0, 0, 0);
        send(1000, y, m); check("R5 b1 tap", y, 7000, 6);
    endtask

    task automatic t_saturate();
        int y, m;
        do_reset();
        phase_inc = 24'h0;
        set_coefs(32767, 0, 0, -16384, 0);
        for (int k = 0; k < 6; k++) send(30000, y, m);
        check("R6 positive clamp", y, 131071, 0);
        send(30000, y, m);
        check("R6 positive clamp holds", y, 131071, 0);
        do_reset();
        for (int k = 0; k < 6; k++) send(-30000, y, m);
        check("R6 negative clamp", y, -131072, 0);
    endtask

    task automatic t_busy_ignore();
        int y, m, pulses, last_y;
        do_reset();
        phase_inc = 24'h400000;
        set_coefs(16384, 0, 0, 0, 0);
        @(negedge clk);
        sample_valid = 1'b1; sample_in = 16'sd10000;
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
        repeat (4) @(negedge clk);
        sample_valid = 1'b1; sample_in = -16'sd20000;
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
        pulses = 0; last_y = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (err_valid) begin pulses++; last_y = int'(err_out); end
        end
        check("R8 one result for two strobes", pulses, 1, 0);
        check("R8 result is first sample", last_y, 10000, 8);
        send(10000, y, m);
        check("R8 phase stepped once", m, 32767, 12);
        check("R8 quadrature product", y, 0, 8);
    endtask

    task automatic t_reset_clears();
        int y, m;
        do_reset();
        phase_inc = 24'h0;
        set_coefs(32767, 0, 0, -16384, 0);
        for (int k = 0; k < 5; k++) send(30000, y, m);
        do_reset();
        check("R1 err_out cleared", int'(err_out), 0, 0);
        check("R1 mod_out cleared", int'(mod_out), 0, 0);
        set_coefs(16384, 0, 0, -8192, 0);
        send(8000, y, m);
        check("R1 no stale feedback", y, 8000, 6);
        check("R1 phase back at zero", m, 0, 12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_quadrants();
        t_fine_phase();
        t_feedback();
        t_taps();
        t_saturate();
        t_busy_ignore();
        t_reset_clears();
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule